// File: doc/BRIEF.md
# Event-Based Branch Control Unit

This unit lets user-level code take a lightweight branch to a handler when an external event or a performance-monitor event arrives, and then return from it. It holds three 64-bit registers: a status-and-control register (a global enable, one enable and one occurred flag per event source, and a two-bit reserved field), a handler address register and a return address register. Event requests are latched as pending. A pending event is delivered only while the global enable and that source's own enable are both set. Delivery is one-shot: it clears the global enable, records the source in its occurred flag, saves the next-instruction address in the return register and redirects fetch to the handler.

The unit also decodes the return-from-event-branch instruction word. A well-formed return redirects fetch to the saved return address, cut to 32 bits in 32-bit mode, and loads the global enable from the instruction's S bit. If the reserved control field is nonzero, the return raises an illegal-instruction strobe instead. Software loads the three registers through a simple write port and reads them on dedicated outputs. Register bits are given below as little-endian indices, where bit 63 is the most significant.

Top module: `evbr_ctrl`

## Requirements
- R1: After reset, all three registers, the redirect strobe, the redirect address and the illegal strobe are zero. No event is pending.
- R2: A write with `wr_en` loads the register chosen by `wr_sel`: 0 selects control, 1 selects handler and 2 selects return. The value 3 changes nothing. The handler and return registers always hold bits [1:0] at zero, whatever was written.
- R3: An event is delivered only when control bit 63 (global enable) is 1 and the source's enable bit is 1: bit 33 for the external source and bit 32 for the performance monitor. A request that cannot be delivered stays pending and is delivered later, once both enables are 1.
- R4: On delivery, control bit 63 becomes 0, the source's occurred bit becomes 1 (bit 1 for external, bit 0 for monitor) and the return register takes `next_ia` with bits [1:0] forced to zero.
- R5: The clock edge that performs a delivery raises `redir_valid` for exactly one cycle, with `redir_addr` equal to the handler register. While `redir_valid` is 0, `redir_addr` is 0.
- R6: When both sources are deliverable in the same cycle, the external event is delivered. The monitor event stays pending and is delivered on the next edge only if the global enable is 1 again.
- R7: A return instruction is recognised when `insn_valid` is 1, bits [31:26] equal 19 and bits [10:1] equal 146. Bit 11 is S, and all other bits are ignored. Any other word causes no redirect and no change to the registers.
- R8: A return with control bits [31:30] both zero redirects to the return register for one cycle and sets control bit 63 equal to S.
- R9: When `mode64` is 0, the redirect target of a return is the return register's low 32 bits, with bits [63:32] zero.
- R10: A return with control bits [31:30] not both zero raises `illegal_insn` for one cycle. It does not redirect and leaves control bit 63 unchanged.
- R11: In a cycle that holds a recognised return, no event is delivered; requests stay pending. In a cycle that holds a recognised return or a delivery, a register write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_evt_req | input | 1 | External event request |
| pm_evt_req | input | 1 | Performance-monitor event request |
| next_ia | input | 64 | Address of the instruction that would execute next |
| mode64 | input | 1 | 1 for 64-bit mode, 0 for 32-bit mode |
| insn_valid | input | 1 | `insn_word` holds an instruction to execute |
| insn_word | input | 32 | Instruction word |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 64 | Write data |
| ctrl_q | output | 64 | Status and control register |
| handler_q | output | 64 | Handler address register |
| return_q | output | 64 | Return address register |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_addr | output | 64 | Fetch redirect target |
| illegal_insn | output | 1 | Illegal-instruction strobe |

## Verification
The assertions assume every input has a known value in each cycle after reset. They assume the write port, the event requests and the instruction word may change in any cycle with no handshake. They make no assumption about the value of `next_ia` or about how often events are requested. The stimulus drives every input at a defined value from time zero and changes inputs only between clock edges. It mixes directed scenarios with a random phase. In that phase, the instruction words are built so that both valid returns and near-miss encodings occur, and the writes often set the reserved field, which exercises the illegal-instruction path.

// File: rtl/evbr_pkg.sv
package evbr_pkg;
  localparam int XLEN = 64;
  localparam int NSRC = 2;  // index 0: external, 1: performance monitor

  // big-endian bit n maps to little-endian bit XLEN-1-n
  localparam int B_GE      = XLEN - 1 - 0;
  localparam int B_EXT_EN  = XLEN - 1 - 30;
  localparam int B_PM_EN   = XLEN - 1 - 31;
  localparam int B_RSV_HI  = XLEN - 1 - 32;
  localparam int B_RSV_LO  = XLEN - 1 - 33;
  localparam int B_EXT_OCC = XLEN - 1 - 62;
  localparam int B_PM_OCC  = XLEN - 1 - 63;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_HANDLER = 2'd1,
    SEL_RETURN  = 2'd2,
    SEL_NONE    = 2'd3
  } wr_sel_e;

  function automatic logic [XLEN-1:0] word_align(input logic [XLEN-1:0] a);
    return {a[XLEN-1:2], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] mode_target(input logic [XLEN-1:0] a,
                                                  input logic m64);
    return m64 ? a : {{(XLEN-32){1'b0}}, a[31:0]};
  endfunction
endpackage

// File: rtl/evbr_decode.sv
module evbr_decode #(
  parameter int PRIMARY_OP = 19,
  parameter int EXT_OP     = 146
) (
  input  logic        valid,
  input  logic [31:0] word,
  output logic        hit,
  output logic        s_bit
);
  localparam logic [5:0] PO = PRIMARY_OP[5:0];
  localparam logic [9:0] XO = EXT_OP[9:0];

  always_comb begin
    hit   = valid && (word[31:26] == PO) && (word[10:1] == XO);
    s_bit = word[11];
  end
endmodule

// File: rtl/evbr_arbiter.sv
module evbr_arbiter #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] src_en,
  input  logic            ge,
  input  logic            block,
  output logic [NSRC-1:0] grant
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_all;
  logic [NSRC-1:0] elig;

  always_comb begin
    pend_all = pend_q | req;
    elig     = pend_all & src_en & {NSRC{ge & ~block}};
    grant    = elig & ~(elig - 1'b1);  // lowest index wins
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_all[i] & ~grant[i];
    end
  end

  assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_needs_ge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (ge && !block));
  assert_blocked_keeps_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> ((pend_q & $past(req)) == $past(req)));
endmodule

// File: rtl/evbr_regs.sv
module evbr_regs
  import evbr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [W-1:0]    wr_data,
  input  logic            busy,
  input  logic            ret_ok,
  input  logic            ret_s,
  input  logic [NSRC-1:0] grant,
  input  logic [W-1:0]    next_ia,
  output logic [W-1:0]    ctrl_q,
  output logic [W-1:0]    handler_q,
  output logic [W-1:0]    return_q
);
  localparam int OCC_POS [NSRC] = '{B_EXT_OCC, B_PM_OCC};

  logic [W-1:0] ctrl_d, handler_d, return_d;
  logic         wr_live;

  always_comb begin
    ctrl_d    = ctrl_q;
    handler_d = handler_q;
    return_d  = return_q;
    wr_live   = wr_en && !busy;
    if (ret_ok) begin
      ctrl_d[B_GE] = ret_s;
    end else if (|grant) begin
      ctrl_d[B_GE] = 1'b0;
      return_d     = word_align(next_ia);
      for (int i = 0; i < NSRC; i++)
        if (grant[i]) ctrl_d[OCC_POS[i]] = 1'b1;
    end else if (wr_live) begin
      case (wr_sel_e'(wr_sel))
        SEL_CTRL:    ctrl_d    = wr_data;
        SEL_HANDLER: handler_d = word_align(wr_data);
        SEL_RETURN:  return_d  = word_align(wr_data);
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      handler_q <= '0;
      return_q  <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      handler_q <= handler_d;
      return_q  <= return_d;
    end
  end

  assert_delivery_clears_ge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> !ctrl_q[B_GE]);
  assert_addr_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_q[1:0] == 2'b00) && (return_q[1:0] == 2'b00));
  assert_busy_drops_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(|grant) && !ret_ok) |=> $stable(handler_q) && $stable(return_q)
                                      && $stable(ctrl_q));
endmodule

// File: rtl/evbr_ctrl.sv
module evbr_ctrl
  import evbr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_evt_req,
  input  logic            pm_evt_req,
  input  logic [XLEN-1:0] next_ia,
  input  logic            mode64,
  input  logic            insn_valid,
  input  logic [31:0]     insn_word,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] ctrl_q,
  output logic [XLEN-1:0] handler_q,
  output logic [XLEN-1:0] return_q,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_addr,
  output logic            illegal_insn
);
  logic            ret_hit, ret_s, ret_bad, ret_ok;
  logic [NSRC-1:0] grant;
  logic            deliver;

  evbr_decode u_decode (
    .valid (insn_valid),
    .word  (insn_word),
    .hit   (ret_hit),
    .s_bit (ret_s)
  );

  always_comb begin
    ret_bad = ret_hit && (ctrl_q[B_RSV_HI:B_RSV_LO] != 2'b00);
    ret_ok  = ret_hit && !ret_bad;
    deliver = |grant;
  end

  evbr_arbiter #(.NSRC(NSRC)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    ({pm_evt_req, ext_evt_req}),
    .src_en ({ctrl_q[B_PM_EN], ctrl_q[B_EXT_EN]}),
    .ge     (ctrl_q[B_GE]),
    .block  (ret_hit),
    .grant  (grant)
  );

  evbr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .busy      (ret_hit | deliver),
    .ret_ok    (ret_ok),
    .ret_s     (ret_s),
    .grant     (grant),
    .next_ia   (next_ia),
    .ctrl_q    (ctrl_q),
    .handler_q (handler_q),
    .return_q  (return_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid  <= 1'b0;
      redir_addr   <= '0;
      illegal_insn <= 1'b0;
    end else begin
      redir_valid  <= ret_ok | deliver;
      illegal_insn <= ret_bad;
      if (ret_ok)       redir_addr <= mode_target(return_q, mode64);
      else if (deliver) redir_addr <= handler_q;
      else              redir_addr <= '0;
    end
  end

  assert_one_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ret_ok, ret_bad, deliver}));
  assert_illegal_keeps_ge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_bad |=> ($stable(ctrl_q[B_GE]) && !redir_valid && illegal_insn));
  assert_return_sets_ge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> (ctrl_q[B_GE] == $past(insn_word[11])));
  assert_narrow_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_ok && !mode64) |=> (redir_addr[XLEN-1:32] == '0));
  assert_idle_addr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |-> (redir_addr == '0));
  assert_redir_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_addr[1:0] == 2'b00));
endmodule

// File: tb/evbr_ctrl_bench.sv
module evbr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_evt_req = 0, pm_evt_req = 0, mode64 = 1, insn_valid = 0, wr_en = 0;
  logic [63:0] next_ia = '0, wr_data = '0;
  logic [31:0] insn_word = '0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] ctrl_q, handler_q, return_q, redir_addr;
  logic        redir_valid, illegal_insn;

  always #2.5 clk = ~clk;  // 200 MHz

  evbr_ctrl u_evbr_ctrl (.*);

  int    n_checks = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  // reference state (big-endian bit k lives at index 63-k)
  logic [63:0] m_ctrl = 0, m_hnd = 0, m_ret = 0, m_ra = 0;
  logic        m_rv = 0, m_ill = 0, m_pe = 0, m_pp = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("redir_valid", 64'(redir_valid), 64'(m_rv));
    chk("redir_addr", redir_addr, m_ra);
    chk("illegal", 64'(illegal_insn), 64'(m_ill));
    chk("ctrl", ctrl_q, m_ctrl);
    chk("handler", handler_q, m_hnd);
    chk("return", return_q, m_ret);
  endtask

  task automatic model_step();
    bit hit, bad, ok, pe, pp, dx, dp;
    hit = insn_valid && insn_word[31:26] == 6'd19 && insn_word[10:1] == 10'd146;
    bad = hit && (m_ctrl[63-32] || m_ctrl[63-33]);
    ok  = hit && !bad;
    pe  = m_pe || ext_evt_req;
    pp  = m_pp || pm_evt_req;
    dx  = !hit && m_ctrl[63] && m_ctrl[63-30] && pe;
    dp  = !hit && m_ctrl[63] && m_ctrl[63-31] && pp && !dx;
    m_rv  = ok || dx || dp;
    m_ill = bad;
    m_ra  = ok ? (mode64 ? m_ret : (m_ret & 64'hFFFF_FFFF)) : ((dx || dp) ? m_hnd : 0);
    m_pe  = pe && !dx;
    m_pp  = pp && !dp;
    if (ok) m_ctrl[63] = insn_word[11];
    else if (dx || dp) begin
      m_ctrl[63] = 0;
      if (dx) m_ctrl[63-62] = 1;
      if (dp) m_ctrl[63-63] = 1;
      m_ret = next_ia & ~64'd3;
    end else if (!bad && wr_en) begin
      if (wr_sel == 0) m_ctrl = wr_data;
      else if (wr_sel == 1) m_hnd = wr_data & ~64'd3;
      else if (wr_sel == 2) m_ret = wr_data & ~64'd3;
    end
  endtask

  // one cycle: check previous edge's outcome, then drive the next inputs
  task automatic cyc(input bit ee = 0, input bit pm = 0, input bit iv = 0,
                     input logic [31:0] iw = 0, input logic [63:0] nia = 0,
                     input bit m64 = 1, input bit we = 0, input logic [1:0] ws = 0,
                     input logic [63:0] wd = 0);
    @(negedge clk);
    compare_all();
    ext_evt_req = ee; pm_evt_req = pm; insn_valid = iv; insn_word = iw;
    next_ia = nia; mode64 = m64; wr_en = we; wr_sel = ws; wr_data = wd;
    model_step();
  endtask

  function automatic logic [31:0] mk_ret(input bit s, input logic [14:0] junk);
    return {6'd19, junk[14:1], s, 10'd146, junk[0]};
  endfunction

  localparam logic [63:0] GE = 64'h8000_0000_0000_0000;
  localparam logic [63:0] EXT_EN = 64'h1 << 33, PM_EN = 64'h1 << 32, RSV = 64'h1 << 31;

  initial begin
    repeat (3) @(negedge clk);
    compare_all();  // R1 reset values, checked while reset is held
    rst_n = 1;
    tag = "R1"; cyc(); cyc();

    tag = "R2";
    cyc(.we(1), .ws(1), .wd(64'h1234_5678_9ABC_DEF3));
    cyc(.we(1), .ws(2), .wd(64'hFFFF_0000_1111_2227));
    cyc(.we(1), .ws(3), .wd(64'hDEAD_BEEF_DEAD_BEEF));
    cyc(.we(1), .ws(0), .wd(64'h0000_0000_4000_0000));
    cyc();

    tag = "R3";  // GE clear: external request must wait
    cyc(.we(1), .ws(0), .wd(EXT_EN));
    cyc(.ee(1), .nia(64'h1000)); cyc(); cyc();
    cyc(.we(1), .ws(0), .wd(GE | EXT_EN));
    tag = "R4"; cyc(.nia(64'h2007));
    tag = "R5"; cyc(); cyc();

    tag = "R6";  // both pending, external first, monitor after GE returns
    cyc(.we(1), .ws(0), .wd(EXT_EN | PM_EN));
    cyc(.ee(1), .pm(1));
    cyc(.we(1), .ws(0), .wd(GE | EXT_EN | PM_EN));
    cyc(.nia(64'h3000)); cyc();
    cyc(.we(1), .ws(0), .wd(GE | EXT_EN | PM_EN));
    cyc(.nia(64'h4004)); cyc();

    tag = "R7";  // near misses
    cyc(.we(1), .ws(2), .wd(64'hAAAA_BBBB_CCCC_DDDC));
    cyc(.iv(1), .iw(mk_ret(1, 15'h7FFF) ^ 32'h0000_0002));
    cyc(.iv(1), .iw(mk_ret(1, 0) ^ 32'h0400_0000));
    cyc(.iv(0), .iw(mk_ret(1, 0)));
    tag = "R8";
    cyc(.iv(1), .iw(mk_ret(1, 15'h5A5A)));
    cyc(); cyc(.iv(1), .iw(mk_ret(0, 15'h1234))); cyc();
    tag = "R9";
    cyc(.iv(1), .iw(mk_ret(1, 0)), .m64(0)); cyc();
    tag = "R10";
    cyc(.we(1), .ws(0), .wd(RSV | EXT_EN));
    cyc(.iv(1), .iw(mk_ret(1, 0))); cyc();
    cyc(.we(1), .ws(0), .wd(GE | (RSV >> 1)));
    cyc(.iv(1), .iw(mk_ret(0, 0))); cyc();

    tag = "R11";
    cyc(.we(1), .ws(0), .wd(GE | EXT_EN));
    cyc(.ee(1), .iv(1), .iw(mk_ret(1, 0)), .we(1), .ws(1), .wd(64'h55));
    cyc(.nia(64'h9000), .we(1), .ws(1), .wd(64'h77)); cyc(); cyc();

    tag = "R5";  // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      logic [63:0] d;
      w = mk_ret($urandom_range(0, 1), 15'($urandom));
      if ($urandom_range(0, 3) == 0) w[10:1] = 10'($urandom);
      d = {$urandom, $urandom};
      if ($urandom_range(0, 2) != 0) d[31:30] = 2'b00;
      cyc(.ee($urandom_range(0, 3) == 0), .pm($urandom_range(0, 3) == 0),
          .iv($urandom_range(0, 4) == 0), .iw(w), .nia({$urandom, $urandom}),
          .m64($urandom_range(0, 1) == 1), .we($urandom_range(0, 2) == 0),
          .ws(2'($urandom)), .wd(d));
    end
    cyc(); cyc();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule